// File: doc/BRIEF.md
# Peripheral Bus Router with Width Splitting

This block sits between a CPU-side I/O bus and a set of peripheral ports. Each CPU access carries a 32-bit address, a size code (byte, halfword or word), a write flag and write data. The router decodes the address inside a fixed I/O page and sends the access to one of four targets. These are a byte-wide serial data FIFO port, a byte-wide disc controller with four registers, a halfword-wide sound register port, and a local scratch register RAM that takes every address no port claims.

Some ports are narrower than the request. For those, the router splits the access into a sequence of sub-accesses, lowest part first, and each sub-access waits for the port's acknowledge. Read results are packed little-endian into one CPU read word. A word access to the sound range covers two registers. The upper register is skipped when it lies past the end of the sound range.

The CPU sees `cpu_busy` from the cycle after a request is accepted until the transaction ends. The final cycle of every transaction carries a one-cycle `cpu_done` pulse, and `cpu_rdata` holds the result.

Top module: `periph_bus_router`

## Requirements
- R1: After reset `cpu_busy`, `cpu_done`, `ser_req`, `dsc_req` and `snd_req` are all 0.
- R2: A halfword access to a page offset in [0x1C00, 0x1E00) issues exactly one sound access. Its `snd_addr` is the offset minus 0x1C00, its `snd_be` is 2'b11, and its data passes unchanged in both directions.
- R3: A word access in the sound range issues two halfword sound accesses in order. Bits 15:0 go to the offset and bits 31:16 go to the offset plus 2. A word read packs the two results the same way.
- R4: When the offset plus 2 falls at or past 0x1E00, a word access issues only the lower sound access. A read then returns zero in bits 31:16.
- R5: A byte access in the sound range issues one access at the even halfword address. `snd_be` is 2'b01 for an even address and 2'b10 for an odd one, and the byte is placed on both lanes of `snd_wdata`. A byte read returns the selected lane in bits 7:0.
- R6: Reads of the serial data offset 0x1040 pop one byte per size unit: 1 for a byte, 2 for a halfword, 4 for a word. The first byte popped lands in bits 7:0, the next in bits 15:8, and so on.
- R7: Writes to the serial data offset push 1, 2 or 4 bytes, lowest byte first.
- R8: Offsets 0x1800 to 0x1803 reach the disc port as one byte access each, with `dsc_reg` equal to address bits 1:0.
- R9: Any address no port claims, including addresses outside I/O page 0x1F80, reads and writes the scratch RAM with byte-lane accuracy, and no port request is raised.
- R10: `cpu_busy` rises the cycle after acceptance and stays high until `cpu_done`. `cpu_done` lasts one cycle. At most one port request is active at a time, and only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request strobe, accepted while not busy |
| cpu_we | input | 1 | 1 = write |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_busy | output | 1 | Transaction in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with cpu_done |
| ser_req | output | 1 | Serial FIFO sub-access request |
| ser_we | output | 1 | 1 = push, 0 = pop |
| ser_wdata | output | 8 | Byte to push |
| ser_rdata | input | 8 | Popped byte |
| ser_ack | input | 1 | Serial sub-access complete |
| dsc_req | output | 1 | Disc register access request |
| dsc_we | output | 1 | 1 = write |
| dsc_reg | output | 2 | Register select |
| dsc_wdata | output | 8 | Write byte |
| dsc_rdata | input | 8 | Read byte |
| dsc_ack | input | 1 | Disc access complete |
| snd_req | output | 1 | Sound register access request |
| snd_we | output | 1 | 1 = write |
| snd_addr | output | 9 | Byte offset in sound range, bit 0 zero |
| snd_be | output | 2 | Byte-lane strobes |
| snd_wdata | output | 16 | Write halfword |
| snd_rdata | input | 16 | Read halfword |
| snd_ack | input | 1 | Sound access complete |

## Verification
The assertions assume that each port holds its acknowledge for exactly one cycle per sub-access and raises it only while its request is high. The bench's port models meet this: they raise acknowledge on the falling edge after seeing a pending request, and drop it on the next falling edge. The assertions also assume the CPU raises `cpu_req` only while `cpu_busy` is low. The bench issues one request at a time and waits for `cpu_done` and one more idle cycle before starting the next.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_RAM = 2'd0,
        TGT_SER = 2'd1,
        TGT_DSC = 2'd2,
        TGT_SND = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FIN   = 2'd2
    } seq_st_e;

endpackage

// File: rtl/pbr_decode.sv
module pbr_decode
    import pbr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned WIN_W     = 16,
    parameter int unsigned IO_PAGE   = 32'h1F80,
    parameter int unsigned SER_DATA  = 32'h1040,
    parameter int unsigned DSC_BASE  = 32'h1800,
    parameter int unsigned SND_BASE  = 32'h1C00,
    parameter int unsigned SND_LIMIT = 32'h1E00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output tgt_e              tgt,
    output logic [1:0]        last_idx
);
    localparam int unsigned PAGE_W = ADDR_W - WIN_W;

    logic [WIN_W-1:0] win;
    logic [WIN_W:0]   win_hi;
    logic             page_hit;
    logic             hit_ser;
    logic             hit_dsc;
    logic             hit_snd;
    logic             hi_in_snd;

    always_comb begin
        win       = addr[WIN_W-1:0];
        win_hi    = {1'b0, win} + (WIN_W+1)'(2);
        page_hit  = (addr[ADDR_W-1:WIN_W] == PAGE_W'(IO_PAGE));
        hit_ser   = page_hit && (win == WIN_W'(SER_DATA));
        hit_dsc   = page_hit && (win[WIN_W-1:2] == WIN_W'(DSC_BASE) >> 2);
        hit_snd   = page_hit && (win >= WIN_W'(SND_BASE)) && (win < WIN_W'(SND_LIMIT));
        hi_in_snd = (win_hi < (WIN_W+1)'(SND_LIMIT));

        tgt      = TGT_RAM;
        last_idx = 2'd0;
        if (hit_ser) begin
            tgt = TGT_SER;
            case (size)
                2'd0:    last_idx = 2'd0;
                2'd1:    last_idx = 2'd1;
                default: last_idx = 2'd3;
            endcase
        end else if (hit_dsc) begin
            tgt = TGT_DSC;
        end else if (hit_snd) begin
            tgt = TGT_SND;
            if (size[1] && hi_in_snd) last_idx = 2'd1;
        end
    end

endmodule

// File: rtl/pbr_scratch.sv
module pbr_scratch #(
    parameter int unsigned WORDS = 64,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW+1:0] addr,
    input  logic [1:0]    size,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] mem_q [WORDS];
    logic [3:0]  be;
    logic [31:0] lane_d;
    logic [31:0] word;

    always_comb begin
        case (size)
            2'd0: begin
                be     = 4'b0001 << addr[1:0];
                lane_d = {4{wdata[7:0]}};
            end
            2'd1: begin
                be     = addr[1] ? 4'b1100 : 4'b0011;
                lane_d = {2{wdata[15:0]}};
            end
            default: begin
                be     = 4'b1111;
                lane_d = wdata;
            end
        endcase
        word = mem_q[addr[AW+1:2]];
        case (size)
            2'd0:    rdata = {24'd0, word[{addr[1:0], 3'b000} +: 8]};
            2'd1:    rdata = {16'd0, word[{addr[1], 4'b0000} +: 16]};
            default: rdata = word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) mem_q[addr[AW+1:2]][b*8 +: 8] <= lane_d[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/periph_bus_router.sv
module periph_bus_router
    import pbr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned WIN_W     = 16,
    parameter int unsigned IO_PAGE   = 32'h1F80,
    parameter int unsigned SER_DATA  = 32'h1040,
    parameter int unsigned DSC_BASE  = 32'h1800,
    parameter int unsigned SND_BASE  = 32'h1C00,
    parameter int unsigned SND_LIMIT = 32'h1E00,
    parameter int unsigned RAM_WORDS = 64,
    localparam int unsigned SND_OFF_W = $clog2(SND_LIMIT - SND_BASE),
    localparam int unsigned RAM_AW    = $clog2(RAM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [1:0]           cpu_size,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [31:0]          cpu_wdata,
    output logic                 cpu_busy,
    output logic                 cpu_done,
    output logic [31:0]          cpu_rdata,
    output logic                 ser_req,
    output logic                 ser_we,
    output logic [7:0]           ser_wdata,
    input  logic [7:0]           ser_rdata,
    input  logic                 ser_ack,
    output logic                 dsc_req,
    output logic                 dsc_we,
    output logic [1:0]           dsc_reg,
    output logic [7:0]           dsc_wdata,
    input  logic [7:0]           dsc_rdata,
    input  logic                 dsc_ack,
    output logic                 snd_req,
    output logic                 snd_we,
    output logic [SND_OFF_W-1:0] snd_addr,
    output logic [1:0]           snd_be,
    output logic [15:0]          snd_wdata,
    input  logic [15:0]          snd_rdata,
    input  logic                 snd_ack
);
    typedef struct packed {
        seq_st_e          st;
        tgt_e             tgt;
        logic             we;
        logic [1:0]       size;
        logic [1:0]       idx;
        logic [1:0]       last;
        logic [WIN_W-1:0] addr;
        logic [31:0]      wdata;
        logic [31:0]      rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    tgt_e        dec_tgt;
    logic [1:0]  dec_last;
    logic [31:0] ram_rdata;
    logic        ram_wr;
    logic        issuing;
    logic        sub_ack;
    logic        is_byte;
    logic [31:0] merged;
    logic [SND_OFF_W-2:0] hw_idx;

    pbr_decode #(
        .ADDR_W(ADDR_W), .WIN_W(WIN_W), .IO_PAGE(IO_PAGE), .SER_DATA(SER_DATA),
        .DSC_BASE(DSC_BASE), .SND_BASE(SND_BASE), .SND_LIMIT(SND_LIMIT)
    ) u_dec (
        .addr     (cpu_addr),
        .size     (cpu_size),
        .tgt      (dec_tgt),
        .last_idx (dec_last)
    );

    pbr_scratch #(.WORDS(RAM_WORDS)) u_ram (
        .clk   (clk),
        .wr_en (ram_wr),
        .addr  (ctl_q.addr[RAM_AW+1:0]),
        .size  (ctl_q.size),
        .wdata (ctl_q.wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        issuing = (ctl_q.st == ST_ISSUE);
        is_byte = (ctl_q.size == 2'd0);
        ram_wr  = issuing && (ctl_q.tgt == TGT_RAM) && ctl_q.we;

        case (ctl_q.tgt)
            TGT_SER: sub_ack = ser_ack;
            TGT_DSC: sub_ack = dsc_ack;
            TGT_SND: sub_ack = snd_ack;
            default: sub_ack = 1'b1;
        endcase

        merged = ctl_q.rdata;
        if (!ctl_q.we) begin
            case (ctl_q.tgt)
                TGT_SER: merged[{ctl_q.idx, 3'b000} +: 8] = ser_rdata;
                TGT_DSC: merged[7:0] = dsc_rdata;
                TGT_SND: begin
                    if (is_byte) merged[7:0] = ctl_q.addr[0] ? snd_rdata[15:8] : snd_rdata[7:0];
                    else         merged[{ctl_q.idx[0], 4'b0000} +: 16] = snd_rdata;
                end
                default: merged = ram_rdata;
            endcase
        end

        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    ctl_d.st    = ST_ISSUE;
                    ctl_d.tgt   = dec_tgt;
                    ctl_d.last  = dec_last;
                    ctl_d.idx   = 2'd0;
                    ctl_d.we    = cpu_we;
                    ctl_d.size  = cpu_size;
                    ctl_d.addr  = cpu_addr[WIN_W-1:0];
                    ctl_d.wdata = cpu_wdata;
                    ctl_d.rdata = '0;
                end
            end
            ST_ISSUE: begin
                if (sub_ack) begin
                    ctl_d.rdata = merged;
                    if (ctl_q.idx == ctl_q.last) ctl_d.st  = ST_FIN;
                    else                         ctl_d.idx = ctl_q.idx + 2'd1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        hw_idx    = ctl_q.addr[SND_OFF_W-1:1] + (SND_OFF_W-1)'(ctl_q.idx);
        cpu_busy  = (ctl_q.st != ST_IDLE);
        cpu_done  = (ctl_q.st == ST_FIN);
        cpu_rdata = ctl_q.rdata;

        ser_req   = issuing && (ctl_q.tgt == TGT_SER);
        ser_we    = ctl_q.we;
        ser_wdata = ctl_q.wdata[{ctl_q.idx, 3'b000} +: 8];

        dsc_req   = issuing && (ctl_q.tgt == TGT_DSC);
        dsc_we    = ctl_q.we;
        dsc_reg   = ctl_q.addr[1:0];
        dsc_wdata = ctl_q.wdata[7:0];

        snd_req   = issuing && (ctl_q.tgt == TGT_SND);
        snd_we    = ctl_q.we;
        snd_addr  = {hw_idx, 1'b0};
        snd_be    = is_byte ? (ctl_q.addr[0] ? 2'b10 : 2'b01) : 2'b11;
        snd_wdata = is_byte ? {2{ctl_q.wdata[7:0]}} : ctl_q.wdata[{ctl_q.idx[0], 4'b0000} +: 16];
    end

    // R10
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ser_req, dsc_req, snd_req}));

    // R10
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_req || dsc_req || snd_req) |-> cpu_busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R3
    snd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_req && !snd_ack) |=> snd_req);

    // R3
    snd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_req && snd_ack) |=> (snd_req |-> (snd_addr == $past(snd_addr) + SND_OFF_W'(2))));

    // R6
    ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_req && !ser_ack) |=> ser_req);

endmodule

// File: tb/periph_bus_router_tb.sv
module periph_bus_router_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_busy, cpu_done;
    logic [31:0] cpu_rdata;
    logic        ser_req, ser_we;
    logic [7:0]  ser_wdata;
    logic [7:0]  ser_rdata = '0;
    logic        ser_ack = 1'b0;
    logic        dsc_req, dsc_we;
    logic [1:0]  dsc_reg;
    logic [7:0]  dsc_wdata;
    logic [7:0]  dsc_rdata = '0;
    logic        dsc_ack = 1'b0;
    logic        snd_req, snd_we;
    logic [8:0]  snd_addr;
    logic [1:0]  snd_be;
    logic [15:0] snd_wdata;
    logic [15:0] snd_rdata = '0;
    logic        snd_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0]  ser_src[$];
    logic [7:0]  ser_push[$];
    int          ser_pops;
    logic [7:0]  dsc_regs [4];
    logic [1:0]  dsc_log_reg[$];
    logic [7:0]  dsc_log_dat[$];
    logic [15:0] snd_mem [256];
    logic [8:0]  snd_log_addr[$];
    logic [1:0]  snd_log_be[$];
    logic [15:0] snd_log_dat[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    periph_bus_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .ser_req(ser_req), .ser_we(ser_we), .ser_wdata(ser_wdata), .ser_rdata(ser_rdata), .ser_ack(ser_ack),
        .dsc_req(dsc_req), .dsc_we(dsc_we), .dsc_reg(dsc_reg), .dsc_wdata(dsc_wdata),
        .dsc_rdata(dsc_rdata), .dsc_ack(dsc_ack),
        .snd_req(snd_req), .snd_we(snd_we), .snd_addr(snd_addr), .snd_be(snd_be),
        .snd_wdata(snd_wdata), .snd_rdata(snd_rdata), .snd_ack(snd_ack)
    );

    // Port models: acknowledge one cycle per pending request
    initial begin
        for (int i = 0; i < 256; i++) snd_mem[i] = '0;
        for (int i = 0; i < 4; i++) dsc_regs[i] = '0;
        forever begin
            @(negedge clk);
            if (ser_req && !ser_ack) begin
                if (ser_we) ser_push.push_back(ser_wdata);
                else begin
                    ser_pops++;
                    ser_rdata = (ser_src.size() > 0) ? ser_src.pop_front() : 8'hEE;
                end
                ser_ack = 1'b1;
            end else ser_ack = 1'b0;
            if (dsc_req && !dsc_ack) begin
                dsc_log_reg.push_back(dsc_reg);
                dsc_log_dat.push_back(dsc_wdata);
                if (dsc_we) dsc_regs[dsc_reg] = dsc_wdata;
                else        dsc_rdata = dsc_regs[dsc_reg];
                dsc_ack = 1'b1;
            end else dsc_ack = 1'b0;
            if (snd_req && !snd_ack) begin
                snd_log_addr.push_back(snd_addr);
                snd_log_be.push_back(snd_be);
                snd_log_dat.push_back(snd_wdata);
                if (snd_we) begin
                    if (snd_be[0]) snd_mem[snd_addr[8:1]][7:0]  = snd_wdata[7:0];
                    if (snd_be[1]) snd_mem[snd_addr[8:1]][15:8] = snd_wdata[15:8];
                end else snd_rdata = snd_mem[snd_addr[8:1]];
                snd_ack = 1'b1;
            end else snd_ack = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        ser_push.delete();
        ser_pops = 0;
        dsc_log_reg.delete();
        dsc_log_dat.delete();
        snd_log_addr.delete();
        snd_log_be.delete();
        snd_log_dat.delete();
    endtask

    task automatic access(input bit we, input logic [1:0] size, input logic [31:0] addr,
                          input logic [31:0] wdata, output logic [31:0] rdata);
        int n;
        clear_logs();
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_size = size; cpu_addr = addr; cpu_wdata = wdata;
        @(negedge clk);
        cpu_req = 1'b0;
        check(cpu_busy === 1'b1, "R10 busy after accept", 32'(cpu_busy), 32'd1);
        n = 0;
        while (cpu_done !== 1'b1 && n < 100) begin
            check(cpu_busy === 1'b1, "R10 busy held", 32'(cpu_busy), 32'd1);
            @(negedge clk);
            n++;
        end
        rdata = cpu_rdata;
        check(cpu_done === 1'b1, "R10 done seen", 32'(cpu_done), 32'd1);
        @(negedge clk);
        check(cpu_done === 1'b0 && cpu_busy === 1'b0, "R10 done one cycle",
              {30'd0, cpu_done, cpu_busy}, 32'd0);
    endtask

    task automatic t_reset();
        check({cpu_busy, cpu_done, ser_req, dsc_req, snd_req} === 5'b0, "R1 reset outputs",
              {27'd0, cpu_busy, cpu_done, ser_req, dsc_req, snd_req}, 32'd0);
    endtask

    task automatic t_snd_half();
        logic [31:0] r;
        access(1'b1, 2'd1, 32'h1F80_1C10, 32'h0000_BEEF, r);
        check(snd_log_addr.size() == 1, "R2 one sound write", snd_log_addr.size(), 1);
        if (snd_log_addr.size() == 1) begin
            check(snd_log_addr[0] == 9'h010, "R2 sound offset", 32'(snd_log_addr[0]), 32'h10);
            check(snd_log_be[0] == 2'b11, "R2 both lanes", 32'(snd_log_be[0]), 32'h3);
            check(snd_log_dat[0] == 16'hBEEF, "R2 write data", 32'(snd_log_dat[0]), 32'hBEEF);
        end
        access(1'b0, 2'd1, 32'h1F80_1C10, 32'h0, r);
        check(r == 32'h0000_BEEF, "R2 half read", r, 32'h0000_BEEF);
    endtask

    task automatic t_snd_word();
        logic [31:0] r;
        access(1'b1, 2'd2, 32'h1F80_1C20, 32'h1234_5678, r);
        check(snd_log_addr.size() == 2, "R3 two sound writes", snd_log_addr.size(), 2);
        if (snd_log_addr.size() == 2) begin
            check(snd_log_addr[0] == 9'h020 && snd_log_dat[0] == 16'h5678, "R3 low half first",
                  {7'd0, snd_log_addr[0], snd_log_dat[0]}, {7'd0, 9'h020, 16'h5678});
            check(snd_log_addr[1] == 9'h022 && snd_log_dat[1] == 16'h1234, "R3 high half at +2",
                  {7'd0, snd_log_addr[1], snd_log_dat[1]}, {7'd0, 9'h022, 16'h1234});
        end
        access(1'b0, 2'd2, 32'h1F80_1C20, 32'h0, r);
        check(r == 32'h1234_5678, "R3 word read packed", r, 32'h1234_5678);
    endtask

    task automatic t_snd_edge();
        logic [31:0] r;
        snd_mem[8'hFF] = 16'h0000;
        access(1'b1, 2'd2, 32'h1F80_1DFE, 32'hAAAA_5555, r);
        check(snd_log_addr.size() == 1, "R4 upper half dropped", snd_log_addr.size(), 1);
        if (snd_log_addr.size() == 1)
            check(snd_log_addr[0] == 9'h1FE && snd_log_dat[0] == 16'h5555, "R4 lower half kept",
                  {7'd0, snd_log_addr[0], snd_log_dat[0]}, {7'd0, 9'h1FE, 16'h5555});
        access(1'b0, 2'd2, 32'h1F80_1DFE, 32'h0, r);
        check(r == 32'h0000_5555, "R4 edge word read", r, 32'h0000_5555);
        check(snd_log_addr.size() == 1, "R4 edge read single access", snd_log_addr.size(), 1);
    endtask

    task automatic t_snd_byte();
        logic [31:0] r;
        snd_mem[8'h18] = 16'h0000;
        access(1'b1, 2'd0, 32'h1F80_1C31, 32'h0000_007A, r);
        check(snd_log_addr.size() == 1, "R5 one byte access", snd_log_addr.size(), 1);
        if (snd_log_addr.size() == 1) begin
            check(snd_log_addr[0] == 9'h030, "R5 even address", 32'(snd_log_addr[0]), 32'h30);
            check(snd_log_be[0] == 2'b10, "R5 upper lane strobe", 32'(snd_log_be[0]), 32'h2);
            check(snd_log_dat[0] == 16'h7A7A, "R5 lane replicated", 32'(snd_log_dat[0]), 32'h7A7A);
        end
        check(snd_mem[8'h18] == 16'h7A00, "R5 lower lane untouched", 32'(snd_mem[8'h18]), 32'h7A00);
        access(1'b0, 2'd0, 32'h1F80_1C31, 32'h0, r);
        check(r == 32'h0000_007A, "R5 odd byte read", r, 32'h7A);
        access(1'b0, 2'd0, 32'h1F80_1C30, 32'h0, r);
        check(r == 32'h0 && snd_log_be[0] == 2'b01, "R5 even byte read", r, 32'h0);
    endtask

    task automatic t_ser_read();
        logic [31:0] r;
        ser_src = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        access(1'b0, 2'd1, 32'h1F80_1040, 32'h0, r);
        check(r == 32'h0000_2211, "R6 half read two pops", r, 32'h2211);
        check(ser_pops == 2, "R6 half pop count", ser_pops, 2);
        access(1'b0, 2'd2, 32'h1F80_1040, 32'h0, r);
        check(r == 32'h6655_4433, "R6 word read little-endian", r, 32'h6655_4433);
        check(ser_pops == 4, "R6 word pop count", ser_pops, 4);
    endtask

    task automatic t_ser_write();
        logic [31:0] r;
        access(1'b1, 2'd1, 32'h1F80_1040, 32'h0000_CDAB, r);
        check(ser_push.size() == 2, "R7 half push count", ser_push.size(), 2);
        if (ser_push.size() == 2)
            check(ser_push[0] == 8'hAB && ser_push[1] == 8'hCD, "R7 half low first",
                  {16'd0, ser_push[0], ser_push[1]}, 32'hABCD);
        access(1'b1, 2'd2, 32'h1F80_1040, 32'h0403_0201, r);
        check(ser_push.size() == 4, "R7 word push count", ser_push.size(), 4);
        if (ser_push.size() == 4)
            check({ser_push[0], ser_push[1], ser_push[2], ser_push[3]} == 32'h0102_0304,
                  "R7 word order", {ser_push[0], ser_push[1], ser_push[2], ser_push[3]}, 32'h0102_0304);
    endtask

    task automatic t_dsc();
        logic [31:0] r;
        access(1'b1, 2'd0, 32'h1F80_1802, 32'h0000_005C, r);
        check(dsc_log_reg.size() == 1 && dsc_regs[2] == 8'h5C, "R8 write reg 2",
              32'(dsc_regs[2]), 32'h5C);
        dsc_regs[3] = 8'h9D;
        access(1'b0, 2'd0, 32'h1F80_1803, 32'h0, r);
        check(r == 32'h9D, "R8 read reg 3", r, 32'h9D);
        check(dsc_log_reg.size() == 1 && dsc_log_reg[0] == 2'd3, "R8 reg select",
              dsc_log_reg.size() > 0 ? 32'(dsc_log_reg[0]) : 32'hFFFF, 32'd3);
    endtask

    task automatic t_ram();
        logic [31:0] r;
        access(1'b1, 2'd2, 32'h1F80_1234, 32'hCAFE_F00D, r);
        access(1'b1, 2'd0, 32'h1F80_1235, 32'h0000_0011, r);
        access(1'b0, 2'd2, 32'h1F80_1234, 32'h0, r);
        check(r == 32'hCAFE_110D, "R9 byte merge in RAM", r, 32'hCAFE_110D);
        check(ser_pops == 0 && snd_log_addr.size() == 0 && dsc_log_reg.size() == 0,
              "R9 no port traffic", 32'(ser_pops), 32'd0);
        access(1'b0, 2'd1, 32'h1F80_1236, 32'h0, r);
        check(r == 32'h0000_CAFE, "R9 half read upper", r, 32'hCAFE);
        access(1'b1, 2'd1, 32'h0000_1C40, 32'h0000_4321, r);
        check(snd_log_addr.size() == 0, "R9 other page not sound", snd_log_addr.size(), 0);
        access(1'b0, 2'd1, 32'h0000_1C40, 32'h0, r);
        check(r == 32'h0000_4321, "R9 other page stored", r, 32'h4321);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_snd_half();
        t_snd_word();
        t_snd_edge();
        t_snd_byte();
        t_ser_read();
        t_ser_write();
        t_dsc();
        t_ram();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule